// File: doc/BRIEF.md
# Console peripheral address decoder

This block sits between a 24-bit CPU bus and the peripherals of a game-console glue chip. For each bus request it works out which target is being addressed. The targets are two peripheral timers, the custom-register file (at its own page and at a second alias page), or a small block of internal registers. It also returns the read data for that request. Addresses that select nothing read as zero, and writes to them are dropped.

The two timer selects come from address bits 13:12 inside the timer page. A strap input picks one of three mappings of those two bits. The internal register block holds a read-only identity word, two interrupt registers, a tick-rate register, a configuration register and a write-only command register. Each writable register stores only some of its bits, and byte enables limit each write to the lanes that are asserted. The block repeats every 64 bytes across its 32 KiB window.

The bus handshake is minimal. The selects are combinational while `bus_req` is high. The acknowledge and the read data are registered and appear in the cycle after the request.

Top module: `periph_addr_decoder`

## Requirements
- R1: Inside page $BF, with `map_mode` = 0, bits 13:12 select: 0 none, 1 timer A, 2 timer B, 3 both. Outside page $BF, and while `bus_req` is low, neither timer select is asserted.
- R2: With `map_mode` = 1, bits 13:12 select: 0 none, 1 timer A, 2 timer B, 3 none.
- R3: With `map_mode` = 2, bits 13:12 select: 0 or 1 gives timer A, 2 or 3 gives timer B. `map_mode` = 3 behaves exactly like `map_mode` = 0.
- R4: Pages $DF and $B9 both assert `cust_sel`, and `cust_addr` carries address bits 15:0. `cust_sel` is never asserted together with a timer select.
- R5: The internal register block answers for $B80000–$B87FFF. Only address bits 5:2 pick the register, so the block repeats every 64 bytes. $B88000–$B8FFFF is unmapped.
- R6: Word 0 of the block (offset $00) reads $C0CACAFE, and writes to it have no effect.
- R7: The two interrupt registers, at offsets $08 and $0C, store bits 31:24 only. All their other bits read zero.
- R8: The configuration register at offset $24 stores bits 31:23 only. All its other bits read zero.
- R9: The rate register at offset $20 stores bit 23 only, and `tick_60hz` equals that bit (0 means 50 Hz, 1 means 60 Hz).
- R10: Offset $28 is write-only. It drives `cmd_word`, and a read at $28 returns the configuration register.
- R11: Byte enable bit n (`bus_be[n]`) gates data bits 8n+7:8n of every register write.
- R12: A read returns zero in these cases: unmapped pages, the unused offsets of the block, and a timer-page access with no timer selected. A timer-page access that selects a timer, and any custom-page access, returns `ext_rdata`.
- R13: `bus_ack` follows `bus_req` by one cycle. `bus_rdata` is zero except in the acknowledge cycle of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 24 | Byte address |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| map_mode | input | 2 | Timer-select mapping strap |
| ext_rdata | input | 32 | Read data from timers or custom registers |
| tmr_a_sel | output | 1 | Timer A select |
| tmr_b_sel | output | 1 | Timer B select |
| cust_sel | output | 1 | Custom-register select |
| cust_addr | output | 16 | Offset inside the custom-register page |
| bus_ack | output | 1 | Acknowledge, one cycle after the request |
| bus_rdata | output | 32 | Read data, valid with the acknowledge |
| tick_60hz | output | 1 | Time-of-day rate select |
| cmd_word | output | 32 | Contents of the write-only command register |

## Verification
All four timer codes are swept under every value of `map_mode`. This separates the three mappings and shows that the reserved strap value matches the first. Reads at the block base, at 64-byte aliases and just past the 32 KiB window separate real repetition from a decode that is too wide. Writes of all ones with partial byte enables tell the per-register keep masks apart from the lane gating. A read at the write-only offset shows that it returns the configuration register's value and not the command register's.

// File: rtl/pad_pkg.sv
package pad_pkg;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;

  typedef enum logic [1:0] {
    TMAP_FULL = 2'd0,
    TMAP_EXCL = 2'd1,
    TMAP_PAIR = 2'd2,
    TMAP_RSVD = 2'd3
  } tmap_e;

  typedef enum logic [2:0] {
    RGN_NONE = 3'd0,
    RGN_TMR  = 3'd1,
    RGN_CUST = 3'd2,
    RGN_MIRR = 3'd3,
    RGN_REGS = 3'd4
  } rgn_e;

  localparam logic [DATA_W-1:0] CHIP_ID = 32'hC0CA_CAFE;

  // word indices inside the 64-byte repeating block
  localparam logic [3:0] W_ID       = 4'd0;
  localparam logic [3:0] W_IRQ_EN   = 4'd2;
  localparam logic [3:0] W_IRQ_PEND = 4'd3;
  localparam logic [3:0] W_RATE     = 4'd8;
  localparam logic [3:0] W_CFG      = 4'd9;
  localparam logic [3:0] W_CMD      = 4'd10;

  localparam logic [DATA_W-1:0] KEEP_IRQ  = 32'hFF00_0000;
  localparam logic [DATA_W-1:0] KEEP_CFG  = 32'hFF80_0000;
  localparam logic [DATA_W-1:0] KEEP_RATE = 32'h0080_0000;
  localparam logic [DATA_W-1:0] KEEP_ALL  = 32'hFFFF_FFFF;
  localparam int RATE_BIT = 23;

  // returns {timer_b, timer_a}
  function automatic logic [1:0] tmr_map(input tmap_e mode, input logic [1:0] code);
    logic [1:0] r;
    case (mode)
      TMAP_EXCL: r = (code == 2'd1) ? 2'b01 : (code == 2'd2) ? 2'b10 : 2'b00;
      TMAP_PAIR: r = code[1] ? 2'b10 : 2'b01;
      default:   r = {code[1], code[0]};
    endcase
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] lane_mask(input logic [BE_W-1:0] be);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < BE_W; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] merge_bits(input logic [DATA_W-1:0] old_v,
                                                   input logic [DATA_W-1:0] new_v,
                                                   input logic [DATA_W-1:0] m);
    return (old_v & ~m) | (new_v & m);
  endfunction
endpackage

// File: rtl/pad_region_dec.sv
module pad_region_dec
  import pad_pkg::*;
#(
  parameter int AW        = 24,
  parameter logic [7:0] TMR_PAGE  = 8'hBF,
  parameter logic [7:0] CUST_PAGE = 8'hDF,
  parameter logic [7:0] MIRR_PAGE = 8'hB9,
  parameter logic [7:0] REG_PAGE  = 8'hB8,
  parameter int REPEAT_W  = 6
) (
  input  logic                 req,
  input  logic [AW-1:0]        addr,
  input  tmap_e                mode,
  output rgn_e                 rgn,
  output logic                 tsel_a,
  output logic                 tsel_b,
  output logic                 csel,
  output logic [AW-9:0]        coff,
  output logic [REPEAT_W-3:0]  word
);
  localparam int PAGE_LO = AW - 8;

  logic [7:0] page;
  logic [1:0] tm;

  assign page = addr[AW-1 -: 8];

  always_comb begin
    rgn = RGN_NONE;
    if (page == TMR_PAGE)                               rgn = RGN_TMR;
    else if (page == CUST_PAGE)                         rgn = RGN_CUST;
    else if (page == MIRR_PAGE)                         rgn = RGN_MIRR;
    else if (page == REG_PAGE && !addr[PAGE_LO-1])      rgn = RGN_REGS;
  end

  assign tm     = tmr_map(mode, addr[13:12]);
  assign tsel_a = req && (rgn == RGN_TMR) && tm[0];
  assign tsel_b = req && (rgn == RGN_TMR) && tm[1];
  assign csel   = req && (rgn == RGN_CUST || rgn == RGN_MIRR);
  assign coff   = addr[PAGE_LO-1:0];
  assign word   = addr[REPEAT_W-1:2];
endmodule

// File: rtl/pad_regfile.sv
module pad_regfile
  import pad_pkg::*;
#(
  parameter int DW  = 32,
  parameter int WIW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIW-1:0]   word,
  input  logic [DW/8-1:0]  be,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rd_data,
  output logic             rate_sel,
  output logic [DW-1:0]    cmd_q
);
  logic [DW-1:0] irq_en_q, irq_pend_q, rate_q, cfg_q;
  logic [DW-1:0] lm;

  assign lm = lane_mask(be);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en_q   <= '0;
      irq_pend_q <= '0;
      rate_q     <= '0;
      cfg_q      <= '0;
      cmd_q      <= '0;
    end else if (wr_en) begin
      case (word)
        W_IRQ_EN:   irq_en_q   <= merge_bits(irq_en_q,   wdata, lm & KEEP_IRQ);
        W_IRQ_PEND: irq_pend_q <= merge_bits(irq_pend_q, wdata, lm & KEEP_IRQ);
        W_RATE:     rate_q     <= merge_bits(rate_q,     wdata, lm & KEEP_RATE);
        W_CFG:      cfg_q      <= merge_bits(cfg_q,      wdata, lm & KEEP_CFG);
        W_CMD:      cmd_q      <= merge_bits(cmd_q,      wdata, lm & KEEP_ALL);
        default: ;
      endcase
    end
  end

  always_comb begin
    case (word)
      W_ID:         rd_data = CHIP_ID;
      W_IRQ_EN:     rd_data = irq_en_q;
      W_IRQ_PEND:   rd_data = irq_pend_q;
      W_RATE:       rd_data = rate_q;
      W_CFG, W_CMD: rd_data = cfg_q;
      default:      rd_data = '0;
    endcase
  end

  assign rate_sel = rate_q[RATE_BIT];
endmodule

// File: rtl/periph_addr_decoder.sv
module periph_addr_decoder
  import pad_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic [23:0] bus_addr,
  input  logic [3:0]  bus_be,
  input  logic [31:0] bus_wdata,
  input  logic [1:0]  map_mode,
  input  logic [31:0] ext_rdata,
  output logic        tmr_a_sel,
  output logic        tmr_b_sel,
  output logic        cust_sel,
  output logic [15:0] cust_addr,
  output logic        bus_ack,
  output logic [31:0] bus_rdata,
  output logic        tick_60hz,
  output logic [31:0] cmd_word
);
  localparam int REPEAT_W = 6;
  localparam int WIW      = REPEAT_W - 2;

  rgn_e            rgn;
  tmap_e           mode_e;
  logic [WIW-1:0]  word;
  logic [31:0]     reg_rd;
  logic [31:0]     rd_val;

  // named events for the checker
  logic reg_wr_evt, rd_id_evt, rd_irq_evt;

  assign mode_e = tmap_e'(map_mode);

  pad_region_dec #(.AW(ADDR_W), .REPEAT_W(REPEAT_W)) u_dec (
    .req    (bus_req),
    .addr   (bus_addr),
    .mode   (mode_e),
    .rgn    (rgn),
    .tsel_a (tmr_a_sel),
    .tsel_b (tmr_b_sel),
    .csel   (cust_sel),
    .coff   (cust_addr),
    .word   (word)
  );

  assign reg_wr_evt = bus_req && bus_we && (rgn == RGN_REGS);
  assign rd_id_evt  = bus_req && !bus_we && (rgn == RGN_REGS) && (word == W_ID);
  assign rd_irq_evt = bus_req && !bus_we && (rgn == RGN_REGS) &&
                      (word == W_IRQ_EN || word == W_IRQ_PEND);

  pad_regfile #(.DW(DATA_W), .WIW(WIW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_evt),
    .word     (word),
    .be       (bus_be),
    .wdata    (bus_wdata),
    .rd_data  (reg_rd),
    .rate_sel (tick_60hz),
    .cmd_q    (cmd_word)
  );

  always_comb begin
    case (rgn)
      RGN_TMR:            rd_val = (tmr_a_sel || tmr_b_sel) ? ext_rdata : '0;
      RGN_CUST, RGN_MIRR: rd_val = ext_rdata;
      RGN_REGS:           rd_val = reg_rd;
      default:            rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack   <= bus_req;
      bus_rdata <= (bus_req && !bus_we) ? rd_val : '0;
    end
  end
endmodule

// File: rtl/pad_checker.sv
module pad_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_req,
  input logic        bus_ack,
  input logic [31:0] bus_rdata,
  input logic [1:0]  map_mode,
  input logic        tmr_a_sel,
  input logic        tmr_b_sel,
  input logic        cust_sel,
  input logic        tick_60hz,
  input logic        reg_wr_evt,
  input logic        rd_id_evt,
  input logic        rd_irq_evt
);
  // R13
  ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> bus_ack);
  // R13
  ack_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |=> !bus_ack);
  // R13
  idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ack |-> bus_rdata == 32'h0);
  // R6
  id_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_id_evt |=> bus_rdata == 32'hC0CA_CAFE);
  // R7
  irq_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_irq_evt |=> bus_rdata[23:0] == 24'h0);
  // R4
  sel_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cust_sel && (tmr_a_sel || tmr_b_sel)));
  // R2
  excl_never_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (map_mode == 2'd1) |-> !(tmr_a_sel && tmr_b_sel));
  // R1
  idle_no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |-> !tmr_a_sel && !tmr_b_sel && !cust_sel);
  // R9
  rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr_evt |=> $stable(tick_60hz));
endmodule

bind periph_addr_decoder pad_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req    (bus_req),
  .bus_ack    (bus_ack),
  .bus_rdata  (bus_rdata),
  .map_mode   (map_mode),
  .tmr_a_sel  (tmr_a_sel),
  .tmr_b_sel  (tmr_b_sel),
  .cust_sel   (cust_sel),
  .tick_60hz  (tick_60hz),
  .reg_wr_evt (reg_wr_evt),
  .rd_id_evt  (rd_id_evt),
  .rd_irq_evt (rd_irq_evt)
);

// File: tb/periph_addr_decoder_tb_top.sv
module periph_addr_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] EXT = 32'hA5C3_0F96;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [23:0] bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [1:0]  map_mode = '0;
  logic tmr_a_sel, tmr_b_sel, cust_sel, bus_ack, tick_60hz;
  logic [15:0] cust_addr;
  logic [31:0] bus_rdata, cmd_word;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference state
  logic [31:0] m_irq0 = 0, m_irq1 = 0, m_rate = 0, m_cfg = 0, m_cmd = 0;

  periph_addr_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .map_mode(map_mode), .ext_rdata(EXT), .tmr_a_sel(tmr_a_sel),
    .tmr_b_sel(tmr_b_sel), .cust_sel(cust_sel), .cust_addr(cust_addr),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .tick_60hz(tick_60hz),
    .cmd_word(cmd_word)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] wmask(input logic [3:0] be);
    logic [31:0] r = 0;
    if (be[0]) r |= 32'h0000_00FF;
    if (be[1]) r |= 32'h0000_FF00;
    if (be[2]) r |= 32'h00FF_0000;
    if (be[3]) r |= 32'hFF00_0000;
    return r;
  endfunction

  // expected timer selects {b,a}
  function automatic logic [1:0] exp_tsel(input logic [23:0] a, input logic [1:0] md);
    int code = int'(a[13:12]);
    logic ea = 0, eb = 0;
    if (a[23:16] != 8'hBF) return 2'b00;
    if (md == 2'd1) begin ea = (code == 1); eb = (code == 2); end
    else if (md == 2'd2) begin ea = (code <= 1); eb = (code >= 2); end
    else begin ea = (code == 1 || code == 3); eb = (code >= 2); end
    return {eb, ea};
  endfunction

  function automatic logic [31:0] exp_read(input logic [23:0] a, input logic [1:0] md);
    int off = int'(a[5:0]) & ~3;
    if (a[23:16] == 8'hBF) return (exp_tsel(a, md) != 0) ? EXT : 32'h0;
    if (a[23:16] == 8'hDF || a[23:16] == 8'hB9) return EXT;
    if (a[23:16] == 8'hB8 && !a[15]) begin
      case (off)
        'h00: return 32'hC0CA_CAFE;
        'h08: return m_irq0;
        'h0C: return m_irq1;
        'h20: return m_rate;
        'h24, 'h28: return m_cfg;
        default: return 32'h0;
      endcase
    end
    return 32'h0;
  endfunction

  task automatic model_write(input logic [23:0] a, input logic [3:0] be, input logic [31:0] d);
    int off = int'(a[5:0]) & ~3;
    logic [31:0] m = wmask(be);
    if (a[23:16] != 8'hB8 || a[15]) return;
    case (off)
      'h08: m_irq0 = (m_irq0 & ~(m & 32'hFF00_0000)) | (d & m & 32'hFF00_0000);
      'h0C: m_irq1 = (m_irq1 & ~(m & 32'hFF00_0000)) | (d & m & 32'hFF00_0000);
      'h20: m_rate = (m_rate & ~(m & 32'h0080_0000)) | (d & m & 32'h0080_0000);
      'h24: m_cfg  = (m_cfg  & ~(m & 32'hFF80_0000)) | (d & m & 32'hFF80_0000);
      'h28: m_cmd  = (m_cmd & ~m) | (d & m);
      default: ;
    endcase
  endtask

  // one bus cycle, entered at a falling edge, left at the next falling edge
  task automatic cyc(input string tag, input logic rq, input logic we,
                     input logic [23:0] a, input logic [3:0] be, input logic [31:0] d);
    logic [1:0] ts;
    logic ec;
    logic [31:0] er;
    bus_req = rq; bus_we = we; bus_addr = a; bus_be = be; bus_wdata = d;
    #1;
    ts = rq ? exp_tsel(a, map_mode) : 2'b00;
    ec = rq && (a[23:16] == 8'hDF || a[23:16] == 8'hB9);
    chk({tag, " tmr_a"}, {31'b0, tmr_a_sel}, {31'b0, ts[0]});
    chk({tag, " tmr_b"}, {31'b0, tmr_b_sel}, {31'b0, ts[1]});
    chk({tag, " cust_sel R4"}, {31'b0, cust_sel}, {31'b0, ec});
    if (ec) chk({tag, " cust_addr R4"}, {16'b0, cust_addr}, {16'b0, a[15:0]});
    er = (rq && !we) ? exp_read(a, map_mode) : 32'h0;
    if (rq && we) model_write(a, be, d);
    @(negedge clk);
    chk({tag, " ack R13"}, {31'b0, bus_ack}, {31'b0, rq});
    chk({tag, " rdata"}, bus_rdata, er);
    chk({tag, " tick R9"}, {31'b0, tick_60hz}, {31'b0, m_rate[23]});
    chk({tag, " cmd R10"}, cmd_word, m_cmd);
  endtask

  task automatic rd(input string tag, input logic [23:0] a);
    cyc(tag, 1, 0, a, 4'h0, 32'h0);
  endtask

  task automatic wr(input string tag, input logic [23:0] a, input logic [3:0] be, input logic [31:0] d);
    cyc(tag, 1, 1, a, be, d);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R13 reset ack", {31'b0, bus_ack}, 32'h0);
    chk("R13 reset rdata", bus_rdata, 32'h0);
    chk("R9 reset tick", {31'b0, tick_60hz}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 timer mapping sweep
    for (int m = 0; m < 4; m++) begin
      map_mode = 2'(m);
      for (int s = 0; s < 4; s++) begin
        rd(m == 1 ? "R2" : (m == 2 ? "R3" : (m == 3 ? "R3 rsvd" : "R1")),
           24'hBF0000 | (24'(s) << 12) | 24'h0100);
        cyc("R1 idle", 0, 0, 24'hBF3000, 4'h0, 32'h0);
      end
    end
    map_mode = 2'd0;
    rd("R1 off page", 24'hBE3000);

    // R4 custom page and alias
    rd("R4 native", 24'hDF0123);
    rd("R4 alias", 24'hB90456);

    // R5 R6 identity, repetition, window edge
    rd("R6 id", 24'hB80000);
    rd("R5 alias 64", 24'hB80040);
    rd("R5 top alias", 24'hB87FC0);
    rd("R5 past window", 24'hB88000);
    wr("R6 id write", 24'hB80000, 4'hF, 32'h1234_5678);
    rd("R6 id after write", 24'hB80000);

    // R7 R11 interrupt registers
    wr("R7 irq0 all", 24'hB80008, 4'hF, 32'hFFFF_FFFF);
    rd("R7 irq0 read", 24'hB80008);
    wr("R11 irq0 low lanes", 24'hB80008, 4'h7, 32'h0);
    rd("R11 irq0 kept", 24'hB80008);
    wr("R11 irq0 top lane", 24'hB80008, 4'h8, 32'h5A00_0000);
    rd("R11 irq0 top", 24'hB80008);
    wr("R7 irq1", 24'hB8004C, 4'hF, 32'h3CFF_FFFF);
    rd("R7 irq1 read", 24'hB8000C);

    // R8 R11 configuration
    wr("R11 cfg lane2", 24'hB80024, 4'h4, 32'hFFFF_FFFF);
    rd("R8 cfg bit23", 24'hB80024);
    wr("R8 cfg all", 24'hB80024, 4'hF, 32'hFFFF_FFFF);
    rd("R8 cfg read", 24'hB80024);

    // R9 rate
    wr("R9 rate lane3 only", 24'hB80020, 4'h8, 32'hFFFF_FFFF);
    wr("R9 rate set", 24'hB80020, 4'h4, 32'h0080_0000);
    rd("R9 rate read", 24'hB80020);
    wr("R9 rate clear", 24'hB80060, 4'hF, 32'h0);

    // R10 write-only command
    wr("R10 cmd", 24'hB80028, 4'hF, 32'hDEAD_BEEF);
    rd("R10 cmd read", 24'hB80028);
    wr("R10 cmd alias", 24'hB80068, 4'h1, 32'h0000_0011);

    // R12 zero reads
    rd("R12 unmapped", 24'h000100);
    rd("R12 unused off", 24'hB80014);
    map_mode = 2'd1;
    rd("R12 tmr none", 24'hBF3000);
    map_mode = 2'd0;
    cyc("R13 idle", 0, 0, 24'hB80000, 4'h0, 32'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule